// File: doc/BRIEF.md
# Vector Compress Execution Unit

This unit executes a vector compress operation. It receives a source data vector, a mask vector and the current contents of the destination, all flat bit vectors of `VLEN` bits. Each source element whose mask bit is set is copied into the destination. The copied elements are packed into the lowest destination slots and keep their source order. Every slot above the packed ones, up to the maximum element count, becomes zero.

The unit also decodes the 32-bit instruction word. It rejects an unrecognised encoding and it rejects illegal register choices. A start pulse launches a walk that looks at one source element per clock. A one-cycle done pulse reports the finished result, the packed element count, a write-enable and an illegal flag. Register-file access and exception delivery belong to the surrounding pipeline.

Top module: `vcomp_unit`

## Requirements
- R1: Source element i is copied only when its mask bit is set. Copied elements occupy destination slots 0, 1, 2 and upwards, in ascending source index, with no gaps.
- R2: Only source elements with index below the effective length are examined. The effective length is `vl` clamped to vlmax, where vlmax = `VLEN` / element width.
- R3: On a legal instruction with `vl` equal to zero, `wr_en` stays low. `result` equals the `dst_vec` that was presented with start, and `packed_cnt` is zero.
- R4: On a legal instruction with `vl` > 0, every destination slot from the packed count up to vlmax-1 reads zero.
- R5: The element width field `sew` selects 8 bits (0), 16 bits (1), 32 bits (2) or 64 bits (3). The mask bit for element i sits at bit i*width of `mask_vec`, and all other mask bits are ignored.
- R6: An instruction is recognised when bits [31:26] = 010111, bits [14:12] = 010 and bits [6:0] = 1010111. Bit 25 is ignored. Any other word is illegal. The fields are: destination rd = [11:7], mask register = [19:15], data source = [24:20].
- R7: The instruction is illegal when rd equals the data source register.
- R8: The instruction is illegal when the mask register lies in the destination group rd .. rd+2^`lmul`-1.
- R9: A start while idle is accepted and raises `busy`. Done is a one-cycle pulse, and `wr_en` and `illegal` are asserted only with done. A start while busy is ignored and produces no extra completion.
- R10: `packed_cnt`, valid with done, equals the number of copied elements.
- R11: An illegal instruction completes with `illegal` high and `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (taken while idle) |
| insn | input | 32 | Instruction word |
| sew | input | 2 | Element width code |
| lmul | input | 2 | log2 of destination group size |
| vl | input | IW | Active vector length |
| src_vec | input | VLEN | Source data vector |
| mask_vec | input | VLEN | Mask vector |
| dst_vec | input | VLEN | Current destination contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Result should be written (with done) |
| illegal | output | 1 | Instruction rejected (with done) |
| result | output | VLEN | Compressed destination value |
| packed_cnt | output | IW | Number of elements packed |

## Verification
The bench builds the unit with `VLEN` = 128, so IW = 5. With that size, 8-bit elements give 16 slots and 64-bit elements give only two. A `vl` of 5 at 64-bit width therefore exercises the clamp to vlmax, and a full-length walk at 8-bit width exercises the longest scan. The 5-bit `vl` port reaches past every vlmax. Directed cases cover each width with mask bits set off-stride, an empty mask, zero length and each decode rejection. Random legal cases follow them.

// File: rtl/vcomp_pkg.sv
package vcomp_pkg;

    localparam logic [6:0] OPC_VEC   = 7'b1010111;
    localparam logic [5:0] FUNCT6_CP = 6'b010111;
    localparam logic [2:0] FUNCT3_CP = 3'b010;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } vc_state_e;

    typedef struct packed {
        logic       match;
        logic [4:0] rd;
        logic [4:0] rmask;
        logic [4:0] rsrc;
    } vc_fields_t;

    // log2 of element width in bits
    function automatic int unsigned ew_log2(input logic [1:0] code);
        return 32'd3 + 32'(code);
    endfunction

endpackage

// File: rtl/vcomp_decode.sv
module vcomp_decode
    import vcomp_pkg::*;
(
    input  logic [31:0] insn,
    input  logic [1:0]  lmul,
    output vc_fields_t  fields,
    output logic        legal
);
    logic [5:0] grp_end;
    logic       overlap;

    always_comb begin
        fields.match = (insn[31:26] == FUNCT6_CP) && (insn[14:12] == FUNCT3_CP)
                       && (insn[6:0] == OPC_VEC);
        fields.rd    = insn[11:7];
        fields.rmask = insn[19:15];
        fields.rsrc  = insn[24:20];
        grp_end      = {1'b0, fields.rd} + (6'd1 << lmul);
        overlap      = ({1'b0, fields.rmask} >= {1'b0, fields.rd})
                       && ({1'b0, fields.rmask} < grp_end);
        legal        = fields.match && (fields.rd != fields.rsrc) && !overlap;
    end
endmodule

// File: rtl/vcomp_lane.sv
module vcomp_lane
    import vcomp_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int IW   = $clog2(VLEN / 8) + 1
) (
    input  logic [VLEN-1:0] src,
    input  logic [VLEN-1:0] mask,
    input  logic [VLEN-1:0] acc,
    input  logic [1:0]      sew,
    input  logic [IW-1:0]   rd_idx,
    input  logic [IW-1:0]   wr_idx,
    output logic            sel,
    output logic [VLEN-1:0] merged
);
    localparam logic [VLEN-1:0] ONE = VLEN'(1);

    int unsigned     rd_off;
    int unsigned     wr_off;
    logic [VLEN-1:0] emask;
    logic [VLEN-1:0] elem;
    logic [VLEN-1:0] mask_sh;

    always_comb begin
        rd_off  = 32'(rd_idx) << ew_log2(sew);
        wr_off  = 32'(wr_idx) << ew_log2(sew);
        emask   = (ONE << (32'd1 << ew_log2(sew))) - ONE;
        mask_sh = mask >> rd_off;
        sel     = mask_sh[0];
        elem    = (src >> rd_off) & emask;
        merged  = (acc & ~(emask << wr_off)) | (elem << wr_off);
    end
endmodule

// File: rtl/vcomp_unit.sv
module vcomp_unit
    import vcomp_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int IW   = $clog2(VLEN / 8) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [31:0]     insn,
    input  logic [1:0]      sew,
    input  logic [1:0]      lmul,
    input  logic [IW-1:0]   vl,
    input  logic [VLEN-1:0] src_vec,
    input  logic [VLEN-1:0] mask_vec,
    input  logic [VLEN-1:0] dst_vec,
    output logic            busy,
    output logic            done,
    output logic            wr_en,
    output logic            illegal,
    output logic [VLEN-1:0] result,
    output logic [IW-1:0]   packed_cnt
);
    localparam int NB = VLEN / 8;

    vc_state_e       st;
    vc_fields_t      fld;
    logic            legal;
    logic [IW-1:0]   vlmax;
    logic [IW-1:0]   vl_eff;
    logic [IW-1:0]   vl_r, idx, cnt;
    logic [1:0]      sew_r;
    logic [VLEN-1:0] src_r, mask_r, acc;
    logic            wr_r, ill_r;
    logic            sel;
    logic [VLEN-1:0] merged;

    vcomp_decode u_dec (
        .insn   (insn),
        .lmul   (lmul),
        .fields (fld),
        .legal  (legal)
    );

    vcomp_lane #(.VLEN(VLEN), .IW(IW)) u_lane (
        .src    (src_r),
        .mask   (mask_r),
        .acc    (acc),
        .sew    (sew_r),
        .rd_idx (idx),
        .wr_idx (cnt),
        .sel    (sel),
        .merged (merged)
    );

    always_comb begin
        vlmax  = IW'(NB) >> sew;
        vl_eff = (vl > vlmax) ? vlmax : vl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            idx    <= '0;
            cnt    <= '0;
            vl_r   <= '0;
            sew_r  <= '0;
            src_r  <= '0;
            mask_r <= '0;
            acc    <= '0;
            wr_r   <= 1'b0;
            ill_r  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        src_r  <= src_vec;
                        mask_r <= mask_vec;
                        sew_r  <= sew;
                        vl_r   <= vl_eff;
                        idx    <= '0;
                        cnt    <= '0;
                        if (!legal) begin
                            ill_r <= 1'b1;
                            wr_r  <= 1'b0;
                            acc   <= dst_vec;
                            st    <= ST_FIN;
                        end else if (vl_eff == '0) begin
                            ill_r <= 1'b0;
                            wr_r  <= 1'b0;
                            acc   <= dst_vec;
                            st    <= ST_FIN;
                        end else begin
                            ill_r <= 1'b0;
                            wr_r  <= 1'b1;
                            acc   <= '0;
                            st    <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (sel) begin
                        acc <= merged;
                        cnt <= cnt + 1'b1;
                    end
                    idx <= idx + 1'b1;
                    if (idx == vl_r - 1'b1) st <= ST_FIN;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (st != ST_IDLE);
        done       = (st == ST_FIN);
        wr_en      = done && wr_r;
        illegal    = done && ill_r;
        result     = acc;
        packed_cnt = cnt;
    end
endmodule

// File: rtl/vcomp_chk.sv
module vcomp_chk #(
    parameter int VLEN = 128,
    parameter int IW   = $clog2(VLEN / 8) + 1
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [IW-1:0]   vl,
    input logic [VLEN-1:0] dst_vec,
    input logic            busy,
    input logic            done,
    input logic            wr_en,
    input logic            illegal,
    input logic [VLEN-1:0] result,
    input logic [IW-1:0]   packed_cnt
);
    logic [IW-1:0]   vl_q;
    logic [VLEN-1:0] dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q  <= '0;
            dst_q <= '0;
        end else if (start && !busy) begin
            vl_q  <= vl;
            dst_q <= dst_vec;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R9
    AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (wr_en || illegal) |-> done); // R9
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wr_en); // R11
    AST_CNT_WITHIN_VL: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (packed_cnt <= vl_q)); // R2
    AST_ZERO_VL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (done && !illegal && vl_q == '0) |-> (!wr_en && result == dst_q)); // R3
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(packed_cnt) <= VLEN / 8)); // R10
endmodule

bind vcomp_unit vcomp_chk #(.VLEN(VLEN), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .vl         (vl),
    .dst_vec    (dst_vec),
    .busy       (busy),
    .done       (done),
    .wr_en      (wr_en),
    .illegal    (illegal),
    .result     (result),
    .packed_cnt (packed_cnt)
);

// File: tb/vcomp_unit_tb.sv
module vcomp_unit_tb_top;
    localparam int VLEN = 128;
    localparam int IW   = $clog2(VLEN / 8) + 1;

    typedef struct {
        logic [VLEN-1:0] res;
        int              cnt;
        bit              wr;
        bit              ill;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [31:0]     insn = '0;
    logic [1:0]      sew = '0;
    logic [1:0]      lmul = '0;
    logic [IW-1:0]   vl = '0;
    logic [VLEN-1:0] src_vec = '0, mask_vec = '0, dst_vec = '0;
    logic            busy, done, wr_en, illegal;
    logic [VLEN-1:0] result;
    logic [IW-1:0]   packed_cnt;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    vcomp_unit #(.VLEN(VLEN), .IW(IW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .insn(insn), .sew(sew),
        .lmul(lmul), .vl(vl), .src_vec(src_vec), .mask_vec(mask_vec),
        .dst_vec(dst_vec), .busy(busy), .done(done), .wr_en(wr_en),
        .illegal(illegal), .result(result), .packed_cnt(packed_cnt)
    );

    function automatic logic [31:0] mk(input int rd, input int rm, input int rs, input bit b25);
        return {6'b010111, b25, 5'(rs), 5'(rm), 3'b010, 5'(rd), 7'b1010111};
    endfunction

    function automatic exp_t model(input logic [31:0] w, input logic [1:0] s, input logic [1:0] lm,
                                   input int vlen_in, input logic [VLEN-1:0] sv,
                                   input logic [VLEN-1:0] mv, input logic [VLEN-1:0] dv);
        exp_t e;
        int ew, vmax, vle, rd, rm, rs, n;
        bit ok;
        ew   = 8 << s;
        vmax = VLEN / ew;
        vle  = (vlen_in > vmax) ? vmax : vlen_in;
        rd = int'(w[11:7]); rm = int'(w[19:15]); rs = int'(w[24:20]);
        ok = (w[31:26] == 6'b010111) && (w[14:12] == 3'b010) && (w[6:0] == 7'b1010111)
             && (rd != rs) && !((rm >= rd) && (rm < rd + (1 << lm)));
        e.ill = !ok;
        e.wr  = ok && (vle > 0);
        e.res = '0;
        n = 0;
        if (e.wr) begin
            for (int i = 0; i < vle; i++) begin
                if (mv[i*ew]) begin
                    for (int b = 0; b < ew; b++) e.res[n*ew+b] = sv[i*ew+b];
                    n++;
                end
            end
        end else begin
            e.res = dv;
        end
        e.cnt = n;
        e.tag = "";
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [VLEN-1:0] act, input logic [VLEN-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] w, input logic [1:0] s,
                       input logic [1:0] lm, input int vlen_in, input logic [VLEN-1:0] sv,
                       input logic [VLEN-1:0] mv, input logic [VLEN-1:0] dv, input bit poke);
        exp_t e;
        while (busy) @(negedge clk);
        insn = w; sew = s; lmul = lm; vl = IW'(vlen_in);
        src_vec = sv; mask_vec = mv; dst_vec = dv;
        e = model(w, s, lm, vlen_in, sv, mv, dv);
        e.tag = tag;
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke && busy) begin
            // R9: second start while busy must be ignored
            insn = mk(3, 0, 4, 1'b0); vl = IW'(1); mask_vec = '1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_t e;
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected done", '0, '0);
            end else begin
                e = sb.pop_front();
                check(wr_en == e.wr, e.tag, "wr_en", VLEN'(wr_en), VLEN'(e.wr));
                check(illegal == e.ill, e.tag, "illegal", VLEN'(illegal), VLEN'(e.ill));
                if (!e.ill) begin
                    check(result == e.res, e.tag, "result", result, e.res);
                    check(int'(packed_cnt) == e.cnt, e.tag, "packed_cnt (R10)",
                          VLEN'(packed_cnt), VLEN'(e.cnt));
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VLEN-1:0] a, b, m;
        a = 128'h0f0e0d0c0b0a09080706050403020100;
        b = 128'hdeadbeef_cafef00d_12345678_9abcdef0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !wr_en && !illegal, "R9", "reset state",
              VLEN'({busy, done, wr_en, illegal}), '0);

        run("R1_alt8",   mk(8, 0, 16, 0), 2'd0, 2'd0, 16, a, 128'h00ff00ff00ff00ff00ff00ff00ff00ff & {16{8'h01}}, '1, 0);
        run("R2_vl10",   mk(8, 0, 16, 0), 2'd0, 2'd0, 10, a, '1, '1, 0);
        run("R5_w16",    mk(8, 0, 16, 0), 2'd1, 2'd0, 8,  b, 128'h0000fffe_0001fffe_00010000_fffe0001, '1, 0);
        run("R5_w32",    mk(8, 0, 16, 0), 2'd2, 2'd0, 4,  b, 128'hfffffffe_00000001_fffffffe_00000001, '1, 0);
        run("R2_clamp64",mk(8, 0, 16, 0), 2'd3, 2'd0, 5,  b, 128'h1_00000000_00000001, '1, 0);
        run("R3_vl0",    mk(8, 0, 16, 0), 2'd0, 2'd0, 0,  a, '1, b, 0);
        run("R4_empty",  mk(8, 0, 16, 0), 2'd0, 2'd0, 16, a, '0, '1, 0);
        run("R6_bit25",  mk(8, 0, 16, 1), 2'd0, 2'd0, 7,  b, 128'h0101, '1, 0);
        run("R6_badopc", mk(8, 0, 16, 0) ^ 32'h1, 2'd0, 2'd0, 4, a, '1, '1, 0);
        run("R6_badf3",  mk(8, 0, 16, 0) ^ 32'h2000, 2'd0, 2'd0, 4, a, '1, '1, 0);
        run("R7_rdsrc",  mk(9, 0, 9, 0), 2'd0, 2'd0, 4, a, '1, '1, 0);
        run("R11_rdsrc", mk(5, 0, 5, 0), 2'd1, 2'd0, 4, a, '1, '1, 0);
        run("R8_ovl",    mk(8, 11, 16, 0), 2'd0, 2'd2, 4, a, '1, '1, 0);
        run("R8_edge",   mk(8, 12, 16, 0), 2'd0, 2'd2, 4, a, '1, '1, 0);
        run("R8_same",   mk(8, 8, 16, 0), 2'd0, 2'd0, 4, a, '1, '1, 0);
        run("R9_busy",   mk(8, 0, 16, 0), 2'd0, 2'd0, 12, a, 128'h0001000100010001, '1, 1);

        for (int k = 0; k < 40; k++) begin
            m = {$urandom, $urandom, $urandom, $urandom};
            a = {$urandom, $urandom, $urandom, $urandom};
            run("R1_rand", mk(8, 0, 16, 0), 2'($urandom_range(0, 3)), 2'd0,
                $urandom_range(1, 31), a, m, '1, 0);
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9", "pending completions", VLEN'(sb.size()), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule